// File: doc/BRIEF.md
# Circular Multi-Buffer Region Manager

This block hands out the buffers of one shared memory region to a single producer and a single consumer. The region is cut into `NUM_BUF` slots of `BUF_BYTES` bytes each, so it spans `NUM_BUF * BUF_BYTES` bytes. For example, eight slots of 1024 bytes make 8192 bytes. The producer asks for a slot to fill and the consumer asks for a slot to drain. Each side receives the start address of its slot, keeps the slot until it pulses its done input, and then moves on to the next slot in ring order.

Slot ownership follows an occupancy count. The producer can only get a slot that holds no unread data. The consumer can only get a slot whose fill has already been reported finished. When no suitable slot exists, the side that asked waits, so the faster side settles to the pace of the slower one. The same logic covers three cases:

- With one slot, filling and draining strictly alternate.
- With two slots, the sides swap back and forth (ping-pong).
- With more slots, the sides chase each other around a ring.

Moving the data, issuing bursts and modelling the memory are left to other blocks.

Top module: `ringRegionMgr`

## Requirements
- R1: After reset both grants are low, the filled count is 0, the free count is `NUM_BUF`, and the writer's offered base is the region base (slot 0).
- R2: The base presented for slot i is `REGION_BASE + i * BUF_BYTES`, on `wrBase` for the writer and `rdBase` for the reader.
- R3: A writer request made while the writer holds no slot and the filled count is below `NUM_BUF` raises `wrGrant` on the next clock. `wrGrant` stays high until the cycle in which `wrDone` is high, and it is low on the clock after that.
- R4: While the filled count equals `NUM_BUF`, a writer request is not granted.
- R5: While the filled count is 0, a reader request is not granted. A slot reaches the reader only after the writer's done pulse for it, and a reader request otherwise behaves like a writer request (grant on the next clock, held until `rdDone`).
- R6: Writer and reader each step through the slots in the order 0, 1, …, `NUM_BUF-1` and then wrap to 0. The reader receives the slots in the order the writer completed them.
- R7: The filled count rises by one on a writer done, falls by one on a reader done, and is unchanged when both happen in the same cycle. The free count is always `NUM_BUF` minus the filled count.
- R8: A done pulse from a side that holds no grant changes neither the counts nor that side's slot index.
- R9: With `NUM_BUF` = 1, once the only slot has been filled the writer is refused until the reader has released it. After the release, the writer is granted the same base again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrReq | input | 1 | Writer asks for an empty slot |
| wrGrant | output | 1 | Writer owns the slot at `wrBase` |
| wrBase | output | ADDR_W | Start address of the writer's current slot |
| wrDone | input | 1 | Writer has finished filling its slot |
| rdReq | input | 1 | Reader asks for a filled slot |
| rdGrant | output | 1 | Reader owns the slot at `rdBase` |
| rdBase | output | ADDR_W | Start address of the reader's current slot |
| rdDone | input | 1 | Reader has finished draining its slot |
| fillCount | output | CNT_W | Slots whose fill is complete and not yet released by the reader |
| freeCount | output | CNT_W | Slots available to the writer |

## Verification
The bench drives the ring until it is full and then keeps requesting. A manager that counted one slot too many would let the writer overwrite data the reader has not taken yet. It also requests reads on an empty ring, which catches a design that hands the reader a slot still being filled. Both sides are taken past the last slot, so an index that fails to wrap, or a reader that drifts out of step with the writer, appears as a wrong base. The bench also completes a fill and a drain in the same cycle, which exposes a counter that gives one of the two updates priority. Stray done pulses check that a side without a slot cannot disturb the counts. A one-slot instance confirms that filling and draining strictly alternate.

// File: rtl/ringPkg.sv
package ringPkg;

  // Strobes from the control half to the address datapath.
  typedef struct packed {
    logic wrAdvance;   // writer released its slot: move to the next one
    logic rdAdvance;   // reader released its slot: move to the next one
  } ringStrobe_t;

  localparam int SIDE_WR = 0;
  localparam int SIDE_RD = 1;
  localparam int SIDES   = 2;

endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringPkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int CNT_W   = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             wrDone,
  input  logic             rdReq,
  input  logic             rdDone,
  output logic             wrGrant,
  output logic             rdGrant,
  output logic [CNT_W-1:0] fillCount,
  output logic [CNT_W-1:0] freeCount,
  output ringStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BUF);

  logic wrOwn, rdOwn;
  logic wrFinish, rdFinish;
  logic wrAvail, rdAvail;

  assign wrFinish = wrOwn & wrDone;
  assign rdFinish = rdOwn & rdDone;
  assign wrAvail  = fillCount < FULL;
  assign rdAvail  = fillCount != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOwn     <= 1'b0;
      rdOwn     <= 1'b0;
      fillCount <= '0;
    end else begin
      wrOwn <= wrOwn ? !wrDone : (wrReq && wrAvail);
      rdOwn <= rdOwn ? !rdDone : (rdReq && rdAvail);
      case ({wrFinish, rdFinish})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign wrGrant          = wrOwn;
  assign rdGrant          = rdOwn;
  assign freeCount        = FULL - fillCount;
  assign strobe.wrAdvance = wrFinish;
  assign strobe.rdAdvance = rdFinish;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL); // R7
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrGrant && fillCount == FULL |=> !wrGrant); // R4
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdGrant && fillCount == '0 |=> !rdGrant); // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant && !wrDone |=> wrGrant); // R3
  AST_BOTH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant && wrDone && rdGrant && rdDone |=> $stable(fillCount)); // R7
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !wrGrant && !rdGrant |=> $stable(fillCount)); // R8

endmodule

// File: rtl/ringPath.sv
module ringPath
  import ringPkg::*;
#(
  parameter int              NUM_BUF     = 4,
  parameter int              BUF_BYTES   = 1024,
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrBase,
  output logic [ADDR_W-1:0] rdBase
);

  localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUF - 1);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BUF_BYTES);

  logic [IDX_W-1:0]  slotIdx  [SIDES];
  logic [ADDR_W-1:0] slotBase [SIDES];
  logic              stepSide [SIDES];

  assign stepSide[SIDE_WR] = strobe.wrAdvance;
  assign stepSide[SIDE_RD] = strobe.rdAdvance;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rstN)            slotIdx[s] <= '0;
      else if (stepSide[s]) slotIdx[s] <= (slotIdx[s] == LAST) ? '0 : slotIdx[s] + 1'b1;
    end
    assign slotBase[s] = REGION_BASE + ADDR_W'(slotIdx[s]) * STRIDE;
  end

  assign wrBase = slotBase[SIDE_WR];
  assign rdBase = slotBase[SIDE_RD];

  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAdvance && slotIdx[SIDE_WR] == LAST |=> slotIdx[SIDE_WR] == '0); // R6
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAdvance && slotIdx[SIDE_RD] == LAST |=> slotIdx[SIDE_RD] == '0); // R6
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrAdvance |=> $stable(slotIdx[SIDE_WR])); // R8

endmodule

// File: rtl/ringRegionMgr.sv
module ringRegionMgr
  import ringPkg::*;
#(
  parameter int                NUM_BUF        = 4,
  parameter int                BUF_BYTES      = 1024,
  parameter int                WR_BURST_BYTES = 256,
  parameter int                RD_BURST_BYTES = 128,
  parameter int                MAX_BURSTS     = 5000,
  parameter int                ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE    = 32'h8000_0000,
  parameter int                CNT_W          = $clog2(NUM_BUF + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  output logic              wrGrant,
  output logic [ADDR_W-1:0] wrBase,
  input  logic              wrDone,
  input  logic              rdReq,
  output logic              rdGrant,
  output logic [ADDR_W-1:0] rdBase,
  input  logic              rdDone,
  output logic [CNT_W-1:0]  fillCount,
  output logic [CNT_W-1:0]  freeCount
);

  localparam longint REGION_BYTES = longint'(NUM_BUF) * BUF_BYTES;
  localparam bit CFG_OK =
    (BUF_BYTES % WR_BURST_BYTES == 0) && (BUF_BYTES % RD_BURST_BYTES == 0) &&
    (BUF_BYTES / WR_BURST_BYTES <= MAX_BURSTS) && (BUF_BYTES / RD_BURST_BYTES <= MAX_BURSTS) &&
    (NUM_BUF >= 1) && (REGION_BYTES <= (longint'(1) << ADDR_W));

  if (!CFG_OK) begin : g_badCfg
    initial $error("ringRegionMgr: slot size must hold whole bursts of both sides within the burst limit");
  end

  ringStrobe_t strobe;

  ringCtrl #(
    .NUM_BUF (NUM_BUF),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrReq     (wrReq),
    .wrDone    (wrDone),
    .rdReq     (rdReq),
    .rdDone    (rdDone),
    .wrGrant   (wrGrant),
    .rdGrant   (rdGrant),
    .fillCount (fillCount),
    .freeCount (freeCount),
    .strobe    (strobe)
  );

  ringPath #(
    .NUM_BUF     (NUM_BUF),
    .BUF_BYTES   (BUF_BYTES),
    .ADDR_W      (ADDR_W),
    .REGION_BASE (REGION_BASE)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrBase (wrBase),
    .rdBase (rdBase)
  );

endmodule

// File: tb/ringRegionMgr_bench.sv
module ringRegionMgr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int SZA = 1024;
  localparam logic [31:0] BASEA = 32'h8000_0000;
  localparam int SZB = 256;
  localparam logic [31:0] BASEB = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic aWrReq = 0, aWrDone = 0, aRdReq = 0, aRdDone = 0;
  logic aWrGrant, aRdGrant;
  logic [31:0] aWrBase, aRdBase;
  logic [2:0] aFill, aFree;

  logic bWrReq = 0, bWrDone = 0, bRdReq = 0, bRdDone = 0;
  logic bWrGrant, bRdGrant;
  logic [31:0] bWrBase, bRdBase;
  logic [0:0] bFill, bFree;

  ringRegionMgr #(.NUM_BUF(NA), .BUF_BYTES(SZA), .REGION_BASE(BASEA)) u_ringRegionMgr (
    .clk(clk), .rstN(rstN),
    .wrReq(aWrReq), .wrGrant(aWrGrant), .wrBase(aWrBase), .wrDone(aWrDone),
    .rdReq(aRdReq), .rdGrant(aRdGrant), .rdBase(aRdBase), .rdDone(aRdDone),
    .fillCount(aFill), .freeCount(aFree));

  ringRegionMgr #(.NUM_BUF(1), .BUF_BYTES(SZB), .WR_BURST_BYTES(64), .RD_BURST_BYTES(64),
                  .REGION_BASE(BASEB)) u_single (
    .clk(clk), .rstN(rstN),
    .wrReq(bWrReq), .wrGrant(bWrGrant), .wrBase(bWrBase), .wrDone(bWrDone),
    .rdReq(bRdReq), .rdGrant(bRdGrant), .rdBase(bRdBase), .rdDone(bRdDone),
    .fillCount(bFill), .freeCount(bFree));

  int vecCount = 0;
  int missCount = 0;
  int wrIdxExp = 0;
  logic [31:0] expQ [$];
  logic rdPrev = 1'b0;

  function automatic logic [31:0] baseA(int idx);
    return BASEA + 32'(idx) * 32'(SZA);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every new reader grant must carry the oldest completed slot.
  always @(negedge clk) begin
    if (rstN && aRdGrant && !rdPrev) begin
      if (expQ.size() == 0) check(1'b0, "R5 grant with nothing filled", 64'(aRdBase), 64'(0));
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(aRdBase == e, "R6 reader slot order", 64'(aRdBase), 64'(e));
      end
    end
    rdPrev <= aRdGrant;
  end

  // Driver: fill one slot on instance A and queue its base for the reader.
  task automatic aWrite(input string tag);
    @(negedge clk) aWrReq = 1;
    @(negedge clk);
    check(aWrGrant == 1'b1, "R3 writer grant", 64'(aWrGrant), 64'(1));
    check(aWrBase == baseA(wrIdxExp), tag, 64'(aWrBase), 64'(baseA(wrIdxExp)));
    aWrReq = 0;
    aWrDone = 1;
    expQ.push_back(baseA(wrIdxExp));
    wrIdxExp = (wrIdxExp + 1) % NA;
    @(negedge clk) aWrDone = 0;
    check(aWrGrant == 1'b0, "R3 writer release", 64'(aWrGrant), 64'(0));
  endtask

  task automatic aRead();
    @(negedge clk) aRdReq = 1;
    @(negedge clk);
    check(aRdGrant == 1'b1, "R5 reader grant with filled slot", 64'(aRdGrant), 64'(1));
    aRdReq = 0;
    aRdDone = 1;
    @(negedge clk) aRdDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(aWrGrant == 0 && aRdGrant == 0, "R1 grants low", 64'({aWrGrant, aRdGrant}), 64'(0));
    check(aFill == 0, "R1 fill count", 64'(aFill), 64'(0));
    check(aFree == 3'(NA), "R1 free count", 64'(aFree), 64'(NA));
    check(aWrBase == BASEA, "R1 first writer base", 64'(aWrBase), 64'(BASEA));

    // R5: empty ring refuses the reader
    aRdReq = 1;
    repeat (3) begin
      @(negedge clk);
      check(aRdGrant == 0, "R5 reader blocked on empty", 64'(aRdGrant), 64'(0));
    end
    aRdReq = 0;

    // R8: stray done pulses
    @(negedge clk) begin aWrDone = 1; aRdDone = 1; end
    @(negedge clk) begin aWrDone = 0; aRdDone = 0; end
    @(negedge clk);
    check(aFill == 0, "R8 count after stray done", 64'(aFill), 64'(0));
    check(aWrBase == BASEA && aRdBase == BASEA, "R8 indices after stray done", 64'(aWrBase), 64'(BASEA));

    // Fill the whole ring (R2)
    for (int i = 0; i < NA; i++) aWrite("R2 writer base");
    check(aFill == 3'(NA), "R7 fill after writes", 64'(aFill), 64'(NA));
    check(aFree == 0, "R7 free when full", 64'(aFree), 64'(0));

    // R4: full ring refuses the writer
    @(negedge clk) aWrReq = 1;
    repeat (3) begin
      @(negedge clk);
      check(aWrGrant == 0, "R4 writer blocked on full", 64'(aWrGrant), 64'(0));
    end
    aWrReq = 0;

    aRead();
    check(aFill == 3'(NA - 1), "R7 fill after read", 64'(aFill), 64'(NA - 1));
    aWrite("R6 writer wraps to slot 0");
    check(aFill == 3'(NA), "R7 fill refilled", 64'(aFill), 64'(NA));
    for (int i = 0; i < NA - 1; i++) aRead();
    check(aFill == 1, "R7 fill one left", 64'(aFill), 64'(1));

    // R7: simultaneous completion on both sides
    @(negedge clk) begin aWrReq = 1; aRdReq = 1; end
    @(negedge clk);
    check(aWrGrant && aRdGrant, "R7 both sides granted", 64'({aWrGrant, aRdGrant}), 64'(3));
    check(aWrBase == baseA(wrIdxExp), "R2 writer base concurrent", 64'(aWrBase), 64'(baseA(wrIdxExp)));
    aWrReq = 0; aRdReq = 0;
    aWrDone = 1; aRdDone = 1;
    expQ.push_back(baseA(wrIdxExp));
    wrIdxExp = (wrIdxExp + 1) % NA;
    @(negedge clk) begin aWrDone = 0; aRdDone = 0; end
    check(aFill == 1, "R7 simultaneous done keeps count", 64'(aFill), 64'(1));
    aRead();
    check(aFill == 0 && aFree == 3'(NA), "R7 drained", 64'({aFill, aFree}), 64'({3'd0, 3'(NA)}));
    check(expQ.size() == 0, "R6 all slots delivered", 64'(expQ.size()), 64'(0));

    // R9: single slot alternation
    @(negedge clk) bWrReq = 1;
    @(negedge clk);
    check(bWrGrant == 1 && bWrBase == BASEB, "R9 single slot first fill", 64'(bWrBase), 64'(BASEB));
    bWrReq = 0; bWrDone = 1;
    @(negedge clk) begin bWrDone = 0; bWrReq = 1; end
    repeat (3) begin
      @(negedge clk);
      check(bWrGrant == 0, "R9 writer waits for reader", 64'(bWrGrant), 64'(0));
    end
    bWrReq = 0;
    bRdReq = 1;
    @(negedge clk);
    check(bRdGrant == 1 && bRdBase == BASEB, "R9 reader gets single slot", 64'(bRdBase), 64'(BASEB));
    bRdReq = 0; bRdDone = 1;
    @(negedge clk) begin bRdDone = 0; bWrReq = 1; end
    @(negedge clk);
    check(bWrGrant == 1 && bWrBase == BASEB, "R9 refill after release", 64'(bWrBase), 64'(BASEB));
    bWrReq = 0; bWrDone = 1;
    @(negedge clk) bWrDone = 0;
    check(bFill == 1, "R9 single slot filled again", 64'(bFill), 64'(1));

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule